// File: doc/BRIEF.md
# Indexed Block Register Target for a Two-Wire System Bus

This block is a target-only SMBus agent that holds the control settings of a differential clock fan-out stage. It runs from a fast system clock that oversamples the bus lines. Software on the bus host writes a starting register index, then a byte count, then that many data bytes, which land in consecutive registers. The register contents drive parallel outputs that the clock output controller uses directly.

Reading starts the same way: the host writes the starting index, issues a repeated start, and addresses the target for reading. The target first returns a fixed count byte and then streams register contents from the index onward. It stops when the host declines a byte.

Start and stop conditions resynchronise the byte engine wherever they occur. Writes to the identity register or to unused indices are accepted but have no effect. The data line is only ever pulled low; releasing it lets the pull-up raise it.

Top module: `smbus_idx_regs`

## Requirements
- R1: After reset, cfg_ctrl is 0x07, cfg_oe is 0xFF, cfg_stop is 0x00 and sda_oe is 0.
- R2: Only an address byte whose upper seven bits are 1101110 is acknowledged. Any other address gets no acknowledge and changes no register.
- R3: In a write frame (address with bit0 = 0, index, count N, N data bytes) every byte is acknowledged. Data byte k goes to register index+k, with cfg_ctrl at index 0, cfg_oe at index 1 and cfg_stop at index 2.
- R4: A count byte of 0 is not acknowledged, and the data bytes that follow it in the same frame change no register.
- R5: Writes to index 4 (identity, always reads 0x20) or to index 3 or 5 and above are acknowledged but discarded.
- R6: After the index write, a repeated start and an address with bit0 = 1 make the target send the count byte 0x05 first. It then sends register contents from the index upward, one per byte, until the host answers a byte with no acknowledge.
- R7: Reads of index 3 and of index 5 and above return 0x00.
- R8: Data bytes beyond the written count are not acknowledged and are discarded.
- R9: A stop or a start at any bit position abandons the current byte, and the next complete frame is handled normally.
- R10: sda_oe changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low |
| cfg_ctrl | output | 8 | Index 0: divide, bypass, bandwidth and float selects |
| cfg_oe | output | 8 | Index 1: per-output enable mask |
| cfg_stop | output | 8 | Index 2: per-output stop mask |

## Verification
The assertions assume that the host changes SDA only while SCL is low, except when it makes a start or stop. They also assume that each SCL phase lasts well beyond the two-flop synchroniser delay, so the target's drive changes settle before SCL rises. The bench's bit-banged host holds every SCL half-period for eight system clocks and moves its data line only in the low phase. Its start and stop tasks make the only high-phase edges. Random frames keep their indices and counts inside the small register window the model covers.

// File: rtl/smbus_idx_regs.sv
module smbus_idx_regs #(
  parameter logic [6:0] SLV_ADDR = 7'h6E,
  parameter logic [7:0] R0_RST   = 8'h07,
  parameter logic [7:0] R1_RST   = 8'hFF,
  parameter logic [7:0] R2_RST   = 8'h00,
  parameter logic [7:0] ID_VAL   = 8'h20,
  parameter logic [7:0] ID_IDX   = 8'd4,
  parameter logic [7:0] SPAN     = 8'd5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] cfg_ctrl,
  output logic [7:0] cfg_oe,
  output logic [7:0] cfg_stop
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_OFS, S_CNT, S_WDAT, S_TX} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  st_t        state;
  logic [3:0] bitcnt;
  logic [6:0] shreg;
  logic [7:0] ptr, remain, txb, rd_val;
  logic       txing, first, ack_pend;

  wire scl_s   = scl_sy[1];
  wire sda_s   = sda_sy[1];
  wire start_c = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c  = scl_s & scl_q & ~sda_q & sda_s;
  wire rise    = scl_s & ~scl_q;
  wire fall    = ~scl_s & scl_q;
  wire [7:0] rx = {shreg, sda_s};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i}; sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;              sda_q  <= sda_s;
    end

  always_comb
    case (ptr)
      8'd0:    rd_val = cfg_ctrl;
      8'd1:    rd_val = cfg_oe;
      8'd2:    rd_val = cfg_stop;
      ID_IDX:  rd_val = ID_VAL;
      default: rd_val = 8'h00;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; bitcnt <= '0; shreg <= '0; ptr <= '0; remain <= '0;
      txb <= '0; txing <= 1'b0; first <= 1'b0; ack_pend <= 1'b0; sda_oe <= 1'b0;
      cfg_ctrl <= R0_RST; cfg_oe <= R1_RST; cfg_stop <= R2_RST;
    end else if (start_c) begin
      state <= S_ADDR; bitcnt <= '0; txing <= 1'b0; ack_pend <= 1'b0; sda_oe <= 1'b0;
    end else if (stop_c) begin
      state <= S_IDLE; bitcnt <= '0; txing <= 1'b0; ack_pend <= 1'b0; sda_oe <= 1'b0;
    end else if (state != S_IDLE) begin
      if (rise) begin
        if (bitcnt != 4'd8) begin
          shreg  <= rx[6:0];
          bitcnt <= bitcnt + 4'd1;
          if (bitcnt == 4'd7) begin
            ack_pend <= 1'b0;
            if (!txing)
              case (state)
                S_ADDR:
                  if (rx[7:1] == SLV_ADDR) begin
                    ack_pend <= 1'b1; first <= 1'b1;
                    state <= rx[0] ? S_TX : S_OFS;
                  end else state <= S_IDLE;
                S_OFS: begin ptr <= rx; ack_pend <= 1'b1; state <= S_CNT; end
                S_CNT:
                  if (rx == 8'd0) state <= S_IDLE;
                  else begin remain <= rx; ack_pend <= 1'b1; state <= S_WDAT; end
                S_WDAT:
                  if (remain == 8'd0) state <= S_IDLE;
                  else begin
                    case (ptr)
                      8'd0: cfg_ctrl <= rx;
                      8'd1: cfg_oe   <= rx;
                      8'd2: cfg_stop <= rx;
                      default: ;
                    endcase
                    ptr <= ptr + 8'd1; remain <= remain - 8'd1; ack_pend <= 1'b1;
                  end
                default: ;
              endcase
          end
        end else begin
          bitcnt <= '0;
          if (txing && sda_s) begin
            state <= S_IDLE; txing <= 1'b0;
          end else if (state == S_TX) begin
            txb <= first ? SPAN : rd_val;
            if (!first) ptr <= ptr + 8'd1;
            first <= 1'b0; txing <= 1'b1;
          end
        end
      end
      if (fall) begin
        if (bitcnt == 4'd8) sda_oe <= ack_pend;
        else                sda_oe <= txing & ~txb[3'd7 - bitcnt[2:0]];
      end
    end
endmodule

// File: rtl/smbus_idx_regs_chk.sv
module smbus_idx_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic [7:0] cfg_ctrl,
  input logic [7:0] cfg_oe,
  input logic [7:0] cfg_stop,
  input logic [2:0] st,
  input logic       stop_c
);
  localparam logic [2:0] ST_IDLE = 3'd0;
  localparam logic [2:0] ST_WDAT = 3'd4;

  p_reset_vals_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cfg_ctrl == 8'h07 && cfg_oe == 8'hFF && cfg_stop == 8'h00 && !sda_oe));

  p_drive_needs_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(st) != ST_IDLE);

  p_cfg_only_in_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({cfg_ctrl, cfg_oe, cfg_stop}) |-> $past(st) == ST_WDAT);

  p_stop_releases_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !sda_oe);

  p_sda_moves_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);
endmodule

bind smbus_idx_regs smbus_idx_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .cfg_ctrl(cfg_ctrl), .cfg_oe(cfg_oe), .cfg_stop(cfg_stop),
  .st(state), .stop_c(stop_c)
);

// File: tb/tb_smbus_idx_regs.sv
module tb_smbus_idx_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [7:0] cfg_ctrl, cfg_oe, cfg_stop;
  wire sda_bus = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  smbus_idx_regs dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .cfg_ctrl(cfg_ctrl), .cfg_oe(cfg_oe), .cfg_stop(cfg_stop)
  );

  int n_chk = 0, n_fail = 0, viol = 0;
  logic done = 1'b0;
  logic [7:0] m [0:2];
  logic [7:0] wbuf [0:7];
  logic [7:0] rbuf [0:7];
  logic prev_oe = 1'b0;

  always @(negedge clk) begin
    if (rst_n && sda_oe != prev_oe && scl_m) viol++;
    prev_oe <= sda_oe;
  end

  task automatic check(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input int idx);
    if (idx < 3) return m[idx];
    if (idx == 4) return 8'h20;
    return 8'h00;
  endfunction

  task automatic hp; repeat (8) @(negedge clk); endtask
  task automatic bstart; sda_m = 1'b1; hp; scl_m = 1'b1; hp; sda_m = 1'b0; hp; scl_m = 1'b0; hp; endtask
  task automatic bstop; sda_m = 1'b0; hp; scl_m = 1'b1; hp; sda_m = 1'b1; hp; endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hp; scl_m = 1'b1; hp; scl_m = 1'b0;
    end
    sda_m = 1'b1; hp; scl_m = 1'b1; hp; ack = ~sda_bus; scl_m = 1'b0;
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hp; scl_m = 1'b1; hp; b[i] = sda_bus; scl_m = 1'b0;
    end
    sda_m = ~mack; hp; scl_m = 1'b1; hp; scl_m = 1'b0;
  endtask

  task automatic wr_frame(input logic [6:0] a, input logic [7:0] ofs, input logic [7:0] cnt,
                          input int nd, output logic [15:0] am);
    am = '0;
    bstart;
    wbyte({a, 1'b0}, am[0]);
    wbyte(ofs, am[1]);
    wbyte(cnt, am[2]);
    for (int i = 0; i < nd; i++) wbyte(wbuf[i], am[3+i]);
    bstop;
  endtask

  task automatic rd_frame(input logic [7:0] ofs, input int nd, output logic [7:0] cnt_got, output logic acks_ok);
    logic a0, a1, a2;
    bstart;
    wbyte(8'hDC, a0);
    wbyte(ofs, a1);
    bstart;
    wbyte(8'hDD, a2);
    rbyte(nd > 0, cnt_got);
    for (int i = 0; i < nd; i++) rbyte(i != nd - 1, rbuf[i]);
    bstop;
    acks_ok = a0 & a1 & a2;
  endtask

  task automatic model_wr(input int ofs, input int cnt);
    for (int i = 0; i < cnt; i++) if (ofs + i < 3) m[ofs+i] = wbuf[i];
  endtask

  task automatic check_outs(input string tag);
    check({cfg_ctrl, cfg_oe, cfg_stop} == {m[0], m[1], m[2]}, tag,
          {cfg_oe, cfg_stop}, {m[1], m[2]});
    check(cfg_ctrl == m[0], tag, {8'h0, cfg_ctrl}, {8'h0, m[0]});
  endtask

  initial begin
    logic [15:0] am;
    logic [7:0] cg;
    logic ok;
    void'($urandom(32'd2024));
    m[0] = 8'h07; m[1] = 8'hFF; m[2] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    check(cfg_ctrl == 8'h07, "R1 ctrl", {8'h0, cfg_ctrl}, 16'h07);
    check(cfg_oe == 8'hFF, "R1 oe", {8'h0, cfg_oe}, 16'hFF);
    check(cfg_stop == 8'h00, "R1 stop", {8'h0, cfg_stop}, 16'h00);
    check(!sda_oe, "R1 sda", {15'h0, sda_oe}, 16'h0);

    // R3 block write at index 0
    wbuf[0] = 8'hC2; wbuf[1] = 8'h5A; wbuf[2] = 8'h81;
    wr_frame(7'h6E, 8'd0, 8'd3, 3, am); model_wr(0, 3);
    check(am[5:0] == 6'h3F, "R3 acks", am, 16'h3F);
    check_outs("R3 regs");

    // R6 read from index 0, five bytes
    rd_frame(8'd0, 5, cg, ok);
    check(ok, "R6 addr acks", {15'h0, ok}, 16'h1);
    check(cg == 8'h05, "R6 count", {8'h0, cg}, 16'h05);
    for (int i = 0; i < 5; i++)
      check(rbuf[i] == exp_rd(i), "R6 data", {8'h0, rbuf[i]}, {8'h0, exp_rd(i)});

    // R5 identity and unused writes discarded but acked
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    wr_frame(7'h6E, 8'd3, 8'd3, 3, am);
    check(am[5:0] == 6'h3F, "R5 acks", am, 16'h3F);
    rd_frame(8'd3, 4, cg, ok);
    check(rbuf[0] == 8'h00, "R7 idx3", {8'h0, rbuf[0]}, 16'h00);
    check(rbuf[1] == 8'h20, "R5 idx4", {8'h0, rbuf[1]}, 16'h20);
    check(rbuf[2] == 8'h00, "R7 idx5", {8'h0, rbuf[2]}, 16'h00);
    check(rbuf[3] == 8'h00, "R7 idx6", {8'h0, rbuf[3]}, 16'h00);
    check_outs("R5 regs");

    // R2 foreign address
    wbuf[0] = 8'h00;
    wr_frame(7'h6F, 8'd1, 8'd1, 1, am);
    check(am[0] == 1'b0, "R2 nack", {15'h0, am[0]}, 16'h0);
    check_outs("R2 regs");
    wr_frame(7'h2E, 8'd0, 8'd1, 1, am);
    check(am[0] == 1'b0, "R2 nack2", {15'h0, am[0]}, 16'h0);
    check_outs("R2 regs2");

    // R4 zero count
    wbuf[0] = 8'h12; wbuf[1] = 8'h34;
    wr_frame(7'h6E, 8'd1, 8'd0, 2, am);
    check(am[2:0] == 3'b011, "R4 nack", am, 16'h3);
    check_outs("R4 regs");

    // R8 excess bytes
    wbuf[0] = 8'h3C; wbuf[1] = 8'hEE;
    wr_frame(7'h6E, 8'd1, 8'd1, 2, am); model_wr(1, 1);
    check(am[4:0] == 5'h0F, "R8 acks", am, 16'h0F);
    check_outs("R8 regs");

    // R9 abort mid-byte by stop, then by repeated start
    bstart;
    for (int i = 0; i < 4; i++) begin sda_m = i[0]; hp; scl_m = 1'b1; hp; scl_m = 1'b0; end
    bstop;
    wbuf[0] = 8'h9B;
    wr_frame(7'h6E, 8'd2, 8'd1, 1, am); model_wr(2, 1);
    check(am[3:0] == 4'hF, "R9 after stop", am, 16'hF);
    check_outs("R9 regs");
    bstart;
    wbyte(8'hDC, ok);
    for (int i = 0; i < 3; i++) begin sda_m = 1'b1; hp; scl_m = 1'b1; hp; scl_m = 1'b0; end
    wbuf[0] = 8'h44;
    bstart; wbyte(8'hDC, am[0]); wbyte(8'd0, am[1]); wbyte(8'd1, am[2]); wbyte(wbuf[0], am[3]); bstop;
    model_wr(0, 1);
    check(am[3:0] == 4'hF, "R9 after restart", am, 16'hF);
    check_outs("R9 regs2");

    // random frames
    for (int it = 0; it < 15; it++) begin
      int ofs, cnt;
      ofs = int'($urandom % 5);
      cnt = 1 + int'($urandom % 3);
      for (int i = 0; i < cnt; i++) wbuf[i] = 8'($urandom);
      wr_frame(7'h6E, 8'(ofs), 8'(cnt), cnt, am); model_wr(ofs, cnt);
      check(am[2+cnt -: 3] == 3'b111 && am[2:0] == 3'b111, "R3 rand acks", am, 16'hFFFF);
      check_outs("R3 rand regs");
      rd_frame(8'(ofs), 3, cg, ok);
      check(cg == 8'h05, "R6 rand count", {8'h0, cg}, 16'h05);
      for (int i = 0; i < 3; i++)
        check(rbuf[i] == exp_rd(ofs + i), "R6 rand data", {8'h0, rbuf[i]}, {8'h0, exp_rd(ofs + i)});
    end

    check(viol == 0, "R10 sda moved with scl high", 16'(viol), 16'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule